// File: doc/BRIEF.md
# Observe-Only Boundary Scan Test Port

This block is the serial test port of a memory device whose pins may be watched but never forced. A test controller clocks it through the standard sixteen-state test access state machine on `tck`/`tms`, feeds serial data on `tdi` and reads results on `tdo`. Behind the port sit a 3-bit instruction register, a one-bit pass-through register, a 32-bit identity register holding a fixed code, and a 70-bit pin-capture chain loaded in parallel from the `pin_sample` bus.

Any data shifted into the pin-capture chain stays inside the chain. It never reaches the pins, so the preload half of the sample/preload operation does nothing. The all-zero instruction behaves as a sample. The only difference is that it raises `out_hiz` for as long as it is in force. The downstream output buffers use `out_hiz` to float the device outputs.

Top module: `jtag_observe_tap`

## Requirements
- R1: Whenever the instruction path passes through its capture state, the instruction shift register loads 3'b001. The first three bits seen on `tdo` in the following shift are therefore 1, 0, 0, least significant bit first.
- R2: A code shifted into the instruction register takes effect only on the rising `tck` edge taken in the instruction-update state. Through the exit and pause states before that edge, the previous instruction (and its `out_hiz` value) stays in force.
- R3: The identity instruction (code 3'b001) is in force after `trst_n` and from the edge that enters the reset state of the state machine.
- R4: Code 3'b000 selects the pin-capture chain and holds `out_hiz` at 1 while it is in force.
- R5: Bits shifted into the pin-capture chain never alter anything the device drives. The next capture again returns the live `pin_sample` value, not the shifted-in bits.
- R6: Code 3'b111 and every unlisted code (3'b011, 3'b101, 3'b110) select the one-bit pass-through register. It captures 0, so the first bit out is 0 and the second bit out is the first `tdi` bit.
- R7: Under the identity instruction, the capture loads the 32-bit constant `ID_VALUE`, which shifts out bit 0 first. The 33rd bit out is the first `tdi` bit.
- R8: Codes 3'b000, 3'b010 and 3'b100 select the 70-bit pin-capture chain. Its capture takes `pin_sample`, bit 0 leaves on `tdo` first, and `tdi` enters at bit 69, so the 71st bit out is the first `tdi` bit. Code 3'b010 sets `out_hiz`; code 3'b100 leaves it at 0.
- R9: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only while the state machine is in one of the two shift states.
- R10: Driving `trst_n` low forces the reset state at once. Five consecutive `tck` rising edges with `tms` high reach it from any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | State machine steering input |
| tdi | input | 1 | Serial data in |
| pin_sample | input | 70 | Parallel sample of the device pins |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| out_hiz | output | 1 | Forces device outputs to high impedance |

## Verification
The bench scans one bit past each register's length. A chain that is one bit too long or too short shows up in the wrong bit position, as does one shifting the wrong way. It parks in the exit and pause states after loading a new code to catch an instruction that takes effect early. It then rescans the pin chain after shifting in a pattern that differs from the pins; a design that preloads would return that pattern. It also samples `tdo` just after a rising edge, which exposes a rising-edge output. It counts exactly five `tms`-high edges, which separates a reset that comes one edge early or late. Finally, it drops `trst_n` with no clock running, which shows whether the reset is really asynchronous.

// File: rtl/jtag_observe_pkg.sv
package jtag_observe_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,
    ST_IDLE     = 4'd1,
    ST_DR_SEL   = 4'd2,
    ST_DR_CAP   = 4'd3,
    ST_DR_SHIFT = 4'd4,
    ST_DR_EXIT1 = 4'd5,
    ST_DR_PAUSE = 4'd6,
    ST_DR_EXIT2 = 4'd7,
    ST_DR_UPD   = 4'd8,
    ST_IR_SEL   = 4'd9,
    ST_IR_CAP   = 4'd10,
    ST_IR_SHIFT = 4'd11,
    ST_IR_EXIT1 = 4'd12,
    ST_IR_PAUSE = 4'd13,
    ST_IR_EXIT2 = 4'd14,
    ST_IR_UPD   = 4'd15
  } tap_state_e;

  typedef enum logic [1:0] {
    CH_PASS = 2'd0,
    CH_IDENT = 2'd1,
    CH_PINS = 2'd2
  } chain_sel_e;

  localparam logic [IR_W-1:0] OP_PIN_HIZ  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT    = 3'b001;
  localparam logic [IR_W-1:0] OP_PIN_ZCAP = 3'b010;
  localparam logic [IR_W-1:0] OP_PIN_SAMP = 3'b100;
  localparam logic [IR_W-1:0] OP_PASS     = 3'b111;

endpackage

// File: rtl/tap_state_ctl.sv
module tap_state_ctl
  import jtag_observe_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state,
  output tap_state_e state_nx
);

  always_comb begin
    state_nx = state;
    case (state)
      ST_RESET:    state_nx = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     state_nx = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   state_nx = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   state_nx = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: state_nx = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: state_nx = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: state_nx = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: state_nx = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   state_nx = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   state_nx = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   state_nx = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: state_nx = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: state_nx = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: state_nx = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: state_nx = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   state_nx = tms ? ST_DR_SEL   : ST_IDLE;
      default:     state_nx = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_nx;
  end

endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
  import jtag_observe_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  tap_state_e      state_nx,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] active_ir
);

  logic sr_cap, sr_shift, sr_en;
  logic act_rst, act_load, act_en;
  logic [IR_W-1:0] sr_d, act_d;

  assign sr_cap   = (state == ST_IR_CAP);
  assign sr_shift = (state == ST_IR_SHIFT);
  assign sr_en    = sr_cap | sr_shift;
  assign act_rst  = (state_nx == ST_RESET);
  assign act_load = (state == ST_IR_UPD);
  assign act_en   = act_rst | act_load;

  always_comb begin
    if (sr_cap) sr_d = {{(IR_W-2){1'b0}}, 2'b01};
    else        sr_d = {tdi, ir_sr[IR_W-1:1]};
    act_d = act_rst ? OP_IDENT : ir_sr;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr     <= OP_IDENT;
      active_ir <= OP_IDENT;
    end else begin
      if (sr_en)  ir_sr     <= sr_d;
      if (act_en) active_ir <= act_d;
    end
  end

endmodule

// File: rtl/tap_data_chains.sv
module tap_data_chains
  import jtag_observe_pkg::*;
#(
  parameter int          PIN_W    = 70,
  parameter logic [31:0] ID_VALUE = 32'h5E3A_C0D5
) (
  input  logic             tck,
  input  logic             rst_n,
  input  tap_state_e       state,
  input  logic [IR_W-1:0]  active_ir,
  input  logic             tdi,
  input  logic [PIN_W-1:0] pin_sample,
  output logic             chain_so
);

  localparam int ID_W = 32;

  chain_sel_e sel;
  logic cap, shf;
  logic pass_q;
  logic [ID_W-1:0]  ident_q;
  logic [PIN_W-1:0] pins_q;
  logic pass_en, ident_en, pins_en;
  logic pass_d;
  logic [ID_W-1:0]  ident_d;
  logic [PIN_W-1:0] pins_d;

  always_comb begin
    case (active_ir)
      OP_PIN_HIZ, OP_PIN_ZCAP, OP_PIN_SAMP: sel = CH_PINS;
      OP_IDENT:                             sel = CH_IDENT;
      default:                              sel = CH_PASS;
    endcase
  end

  assign cap = (state == ST_DR_CAP);
  assign shf = (state == ST_DR_SHIFT);

  assign pass_en  = (cap | shf) & (sel == CH_PASS);
  assign ident_en = (cap | shf) & (sel == CH_IDENT);
  assign pins_en  = (cap | shf) & (sel == CH_PINS);

  always_comb begin
    pass_d  = cap ? 1'b0       : tdi;
    ident_d = cap ? ID_VALUE   : {tdi, ident_q[ID_W-1:1]};
    pins_d  = cap ? pin_sample : {tdi, pins_q[PIN_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      pass_q  <= 1'b0;
      ident_q <= '0;
      pins_q  <= '0;
    end else begin
      if (pass_en)  pass_q  <= pass_d;
      if (ident_en) ident_q <= ident_d;
      if (pins_en)  pins_q  <= pins_d;
    end
  end

  always_comb begin
    case (sel)
      CH_PINS:  chain_so = pins_q[0];
      CH_IDENT: chain_so = ident_q[0];
      default:  chain_so = pass_q;
    endcase
  end

endmodule

// File: rtl/jtag_observe_tap.sv
module jtag_observe_tap
  import jtag_observe_pkg::*;
#(
  parameter int          PIN_W    = 70,
  parameter logic [31:0] ID_VALUE = 32'h5E3A_C0D5
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [PIN_W-1:0] pin_sample,
  output logic             tdo,
  output logic             tdo_oe,
  output logic             out_hiz
);

  logic [1:0] rst_sync;
  logic rst_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  tap_state_e state, state_nx;
  logic [IR_W-1:0] ir_sr, active_ir;
  logic chain_so;
  logic in_shift, tdo_d;

  tap_state_ctl u_fsm (
    .tck(tck), .rst_n(rst_n), .tms(tms), .state(state), .state_nx(state_nx)
  );

  tap_instr_reg u_ir (
    .tck(tck), .rst_n(rst_n), .state(state), .state_nx(state_nx), .tdi(tdi),
    .ir_sr(ir_sr), .active_ir(active_ir)
  );

  tap_data_chains #(.PIN_W(PIN_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .rst_n(rst_n), .state(state), .active_ir(active_ir), .tdi(tdi),
    .pin_sample(pin_sample), .chain_so(chain_so)
  );

  assign in_shift = (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
  assign tdo_d    = (state == ST_IR_SHIFT) ? ir_sr[0] : chain_so;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shift;
      if (in_shift) tdo <= tdo_d;
    end
  end

  assign out_hiz = (active_ir == OP_PIN_HIZ) || (active_ir == OP_PIN_ZCAP);

endmodule

// File: rtl/jtag_observe_chk.sv
module jtag_observe_chk
  import jtag_observe_pkg::*;
(
  input logic            tck,
  input logic            rst_n,
  input tap_state_e      state,
  input tap_state_e      state_nx,
  input logic [IR_W-1:0] ir_sr,
  input logic [IR_W-1:0] active_ir,
  input logic            tdo_oe,
  input logic            out_hiz
);

  p_ir_capture_r1: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_IR_CAP) |=> (ir_sr[1:0] == 2'b01));

  p_instr_held_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_IR_UPD && state_nx != ST_RESET) |=> $stable(active_ir));

  p_reset_ident_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |-> (active_ir == OP_IDENT));

  p_zero_code_hiz_r4: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_IR_UPD && ir_sr == OP_PIN_HIZ) |=> out_hiz);

  p_sample_no_hiz_r8: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_IR_UPD && ir_sr == OP_PIN_SAMP) |=> !out_hiz);

  p_oe_shift_only_r9: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT));

endmodule

bind jtag_observe_tap jtag_observe_chk u_chk (
  .tck(tck), .rst_n(rst_n), .state(state), .state_nx(state_nx),
  .ir_sr(ir_sr), .active_ir(active_ir), .tdo_oe(tdo_oe), .out_hiz(out_hiz)
);

// File: tb/sim_jtag_observe_tap.sv
`timescale 1ns/1ps
module sim_jtag_observe_tap;

  localparam logic [31:0] ID_EXP = 32'h5E3A_C0D5;
  localparam int PW = 70;

  logic tck = 1'b0;
  logic trst_n, tms, tdi;
  logic [PW-1:0] pins;
  logic tdo, tdo_oe, out_hiz;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 tck = ~tck;

  jtag_observe_tap #(.PIN_W(PW), .ID_VALUE(ID_EXP)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_sample(pins),
    .tdo(tdo), .tdo_oe(tdo_oe), .out_hiz(out_hiz)
  );

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic tdo_post;
  task automatic step(input logic m, input logic d, output logic so, output logic oe);
    @(negedge tck); #2;
    tms = m; tdi = d;
    so = tdo; oe = tdo_oe;
    @(posedge tck); #2;
    tdo_post = tdo;
  endtask

  task automatic go(input logic m);
    logic s, o;
    step(m, 1'b0, s, o);
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] seen);
    logic s, o;
    go(1); go(1); go(0); go(0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], s, o);
      seen[i] = s;
    end
    go(1); go(0);
  endtask

  task automatic scan_dr(input int n, input logic [79:0] din, output logic [79:0] dout);
    logic s, o;
    dout = '0;
    go(1); go(0); go(0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], s, o);
      dout[i] = s;
    end
    go(1); go(0);
  endtask

  task automatic t_reset;
    logic [79:0] r;
    chk("R10 reset out_hiz", {79'd0, out_hiz}, 80'd0);
    chk("R10 reset tdo_oe", {79'd0, tdo_oe}, 80'd0);
    scan_dr(33, 80'h1, r);
    chk("R3/R7 ident after reset", r[31:0], ID_EXP);
    chk("R7 bit after ident", r[32], 1'b1);
  endtask

  task automatic t_pass;
    logic [2:0] seen;
    logic [79:0] r;
    load_ir(3'b111, seen);
    chk("R1 ir capture pattern", seen, 3'b001);
    scan_dr(2, 80'h1, r);
    chk("R6 pass-through 111", r[1:0], 2'b10);
    load_ir(3'b011, seen);
    scan_dr(2, 80'h1, r);
    chk("R6 unlisted 011", r[1:0], 2'b10);
    load_ir(3'b110, seen);
    scan_dr(2, 80'h0, r);
    chk("R6 unlisted 110", r[1:0], 2'b00);
  endtask

  task automatic t_zero_code;
    logic [2:0] seen;
    logic [79:0] r, d;
    pins = 70'h2A_5C3E_9911_F0E1_7B6D;
    d = 80'h1234_5678_9ABC_DEF0_0F1F;
    load_ir(3'b000, seen);
    chk("R4 zero code out_hiz", out_hiz, 1'b1);
    scan_dr(71, d, r);
    chk("R8 pin capture", r[69:0], pins);
    chk("R8 length 70", r[70], d[0]);
    pins = 70'h15_0A0B_0C0D_0E0F_1020;
    scan_dr(70, 80'h0, r);
    chk("R5 no preload, live pins", r[69:0], pins);
    chk("R4 hiz held", out_hiz, 1'b1);
  endtask

  task automatic t_sample_modes;
    logic [2:0] seen;
    logic [79:0] r;
    load_ir(3'b100, seen);
    chk("R8 sample no hiz", out_hiz, 1'b0);
    pins = 70'h3F_FFFF_0000_AAAA_5555;
    scan_dr(70, {10'd0, ~pins}, r);
    chk("R8 sample capture", r[69:0], pins);
    scan_dr(70, 80'h0, r);
    chk("R5 sample rescan", r[69:0], pins);
    load_ir(3'b010, seen);
    chk("R8 zcap hiz", out_hiz, 1'b1);
    scan_dr(70, 80'h0, r);
    chk("R8 zcap capture", r[69:0], pins);
  endtask

  task automatic t_update_gate;
    logic [2:0] seen;
    logic s, o;
    load_ir(3'b010, seen);
    go(1); go(1); go(0); go(0);
    step(0, 1'b0, s, o); step(0, 1'b0, s, o); step(1, 1'b1, s, o);
    go(0);
    chk("R2 held in pause", out_hiz, 1'b1);
    go(1); go(1);
    chk("R2 held entering update", out_hiz, 1'b1);
    go(0);
    chk("R2 applied after update", out_hiz, 1'b0);
  endtask

  task automatic t_edges;
    logic [2:0] seen;
    logic s0, s1, o;
    load_ir(3'b001, seen);
    chk("R9 oe idle", tdo_oe, 1'b0);
    go(1); go(0); go(0);
    step(0, 1'b0, s0, o);
    chk("R9 oe in shift", o, 1'b1);
    chk("R7 bit0", s0, ID_EXP[0]);
    chk("R9 tdo held after rise", tdo_post, ID_EXP[0]);
    step(1, 1'b0, s1, o);
    chk("R7 bit1", s1, ID_EXP[1]);
    go(1); go(0);
  endtask

  task automatic t_tms_reset;
    logic [2:0] seen;
    load_ir(3'b000, seen);
    go(1); go(0); go(0);
    for (int i = 0; i < 4; i++) go(1);
    chk("R10 four tms-high not yet", out_hiz, 1'b1);
    go(1);
    chk("R10/R3 five tms-high reset", out_hiz, 1'b0);
    go(0);
  endtask

  task automatic t_trst;
    logic [2:0] seen;
    logic [79:0] r;
    load_ir(3'b010, seen);
    @(negedge tck); #3;
    trst_n = 1'b0; #1;
    chk("R10 async trst", out_hiz, 1'b0);
    repeat (2) @(posedge tck);
    #2 trst_n = 1'b1;
    tms = 1'b1;
    repeat (4) @(posedge tck);
    go(0);
    scan_dr(32, 80'h0, r);
    chk("R3 ident after trst", r[31:0], ID_EXP);
  endtask

  initial begin
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; pins = '0;
    repeat (3) @(posedge tck);
    #2 trst_n = 1'b1;
    repeat (4) @(posedge tck);
    #2;
    t_reset_pre();
  end

  task automatic t_reset_pre;
    go(0);
    t_reset();
    t_pass();
    t_zero_code();
    t_sample_modes();
    t_update_gate();
    t_edges();
    t_tms_reset();
    t_trst();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule